// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit linear address into a physical address. It reads a two-level page table from memory. A request carries the linear address, a write flag and a user-mode flag. The walker takes one request at a time. It first reads a directory word at an address taken from a base-address input. It then reads a table word from the page table that the directory word names. The result is either the physical frame joined with the page offset, or a fault code.

Each table word carries five fields: present, writable, user-accessible, accessed and dirty. Both levels are checked against the request. A walk that succeeds sets the accessed flag in both words, and on a write it also sets the dirty flag in the table word. A word is written back to memory only when its flags actually change. All memory traffic goes through one word-wide port with a valid/ready handshake. The response comes back as a single-cycle pulse.

Top module: `ptw_walker`

## Requirements
- R1: The linear address splits into a directory index (bits 31..22), a table index (bits 21..12) and a page offset (bits 11..0). The first memory access is a read at `dir_base + 4*directory index`.
- R2: After a directory word that passes its checks, the second access is a read at `{dirword[31:12], 12'h000} + 4*table index`. On success `rsp_addr = {tableword[31:12], offset}` and `rsp_cause` is 0.
- R3: If bit 0 (present) is clear in the directory word or the table word, the walk ends with `rsp_cause` = 1 (not present). No further memory access is made, and `rsp_addr` returns the linear address.
- R4: A level faults with `rsp_cause` = 2 (protection) in either of two cases: a write meets a word whose bit 1 (writable) is clear, or a user access meets a word whose bit 2 (user) is clear. The present check at a level comes before its protection check, and the directory level is checked before the table level.
- R5: `rsp_write` and `rsp_user` repeat the request's write and user flags during the response pulse, for faults and for successes alike.
- R6: On success the directory word is written back with bit 5 (accessed) set. The table word is then written back with bit 5 set, and also bit 6 (dirty) when the request is a write. The directory write comes first.
- R7: A word whose flags would not change is not written. A faulting walk makes no memory write.
- R8: `req_ready` is high only when idle. The walker accepts a request on the edge where `req_valid` and `req_ready` are both high. `rsp_valid` is a single-cycle pulse, high in the cycle after the last memory access completes.
- R9: Once `mem_valid` is raised, it stays high with `mem_addr`, `mem_we` and `mem_wdata` stable until `mem_ready` is seen. An access completes on the edge where both are high, and read data is taken on that edge.
- R10: After reset, `req_ready` is 1, and `mem_valid` and `rsp_valid` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Walker idle and able to accept |
| req_vaddr | input | 32 | Linear address to translate |
| req_write | input | 1 | Access is a write |
| req_user | input | 1 | Access is made in user mode |
| dir_base | input | 32 | Physical address of the directory |
| mem_valid | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = word write, 0 = word read |
| mem_addr | output | 32 | Memory word address (byte address) |
| mem_wdata | output | 32 | Write data |
| mem_ready | input | 1 | Memory completes the access this cycle |
| mem_rdata | input | 32 | Read data, valid with mem_ready |
| rsp_valid | output | 1 | Response pulse |
| rsp_cause | output | 2 | 0 ok, 1 not present, 2 protection |
| rsp_addr | output | 32 | Physical address, or linear address on fault |
| rsp_write | output | 1 | Write flag of the finished request |
| rsp_user | output | 1 | User flag of the finished request |

## Verification
Each memory access of a walk takes one cycle plus the number of stall cycles the memory model inserts. A walk with `a` accesses and `s` stall cycles per access therefore raises `rsp_valid` at the `a*(s+1)+1`-th falling edge after the accepting clock edge. The bench counts falling edges from acceptance and checks that the pulse appears exactly there. It reads the response fields in that same cycle, and it checks that `req_ready` is still low at that point. The memory model records each completed access on the rising edge. After the response, the bench compares the number, kind and address of the recorded accesses, and the final memory words, with a reference walk computed from the vector.

// File: rtl/ptw_pkg.sv
package ptw_pkg;

    localparam int WORD_W = 32;
    localparam int OFF_W  = 12;
    localparam int IDX_W  = 10;
    localparam int ENT_SH = 2;

    localparam int BIT_PRES  = 0;
    localparam int BIT_WRITE = 1;
    localparam int BIT_USER  = 2;
    localparam int BIT_ACC   = 5;
    localparam int BIT_DIRTY = 6;

    typedef enum logic [1:0] {
        CAUSE_NONE    = 2'd0,
        CAUSE_ABSENT  = 2'd1,
        CAUSE_PROTECT = 2'd2
    } cause_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD_DIR,
        ST_RD_TBL,
        ST_WB_DIR,
        ST_WB_TBL,
        ST_RESP
    } walk_st_e;

    typedef struct packed {
        logic [WORD_W-1:0] vaddr;
        logic              wr;
        logic              usr;
    } xlat_req_t;

    function automatic cause_e entry_check(input logic [WORD_W-1:0] e,
                                           input logic wr, input logic usr);
        if (!e[BIT_PRES])
            return CAUSE_ABSENT;
        if ((wr && !e[BIT_WRITE]) || (usr && !e[BIT_USER]))
            return CAUSE_PROTECT;
        return CAUSE_NONE;
    endfunction

    function automatic logic [WORD_W-1:0] entry_mark(input logic [WORD_W-1:0] e,
                                                     input logic set_dirty);
        logic [WORD_W-1:0] r;
        r = e;
        r[BIT_ACC] = 1'b1;
        if (set_dirty)
            r[BIT_DIRTY] = 1'b1;
        return r;
    endfunction

endpackage

// File: rtl/ptw_perm_chk.sv
module ptw_perm_chk
    import ptw_pkg::*;
#(
    parameter int W = ptw_pkg::WORD_W
) (
    input  logic [W-1:0] entry,
    input  logic         is_wr,
    input  logic         is_usr,
    output cause_e       cause
);
    always_comb begin
        cause = entry_check(entry, is_wr, is_usr);
    end
endmodule

// File: rtl/ptw_flag_upd.sv
module ptw_flag_upd
    import ptw_pkg::*;
#(
    parameter int W = ptw_pkg::WORD_W
) (
    input  logic [W-1:0] entry,
    input  logic         set_dirty,
    output logic [W-1:0] marked,
    output logic         changed
);
    always_comb begin
        marked  = entry_mark(entry, set_dirty);
        changed = (marked != entry);
    end
endmodule

// File: rtl/ptw_addr_gen.sv
module ptw_addr_gen
    import ptw_pkg::*;
#(
    parameter int IDX_W = ptw_pkg::IDX_W,
    parameter int OFF_W = ptw_pkg::OFF_W
) (
    input  walk_st_e                    st,
    input  logic [2*IDX_W+OFF_W-1:0]    base,
    input  logic [2*IDX_W+OFF_W-1:0]    vaddr,
    input  logic [2*IDX_W+OFF_W-1:0]    dir_entry,
    output logic [2*IDX_W+OFF_W-1:0]    addr
);
    localparam int VA_W = 2*IDX_W + OFF_W;

    logic [IDX_W-1:0] dir_idx;
    logic [IDX_W-1:0] tbl_idx;
    logic [VA_W-1:0]  dir_off;
    logic [VA_W-1:0]  tbl_off;
    logic [VA_W-1:0]  tbl_base;

    always_comb begin
        dir_idx  = vaddr[VA_W-1 -: IDX_W];
        tbl_idx  = vaddr[OFF_W +: IDX_W];
        dir_off  = VA_W'({dir_idx, {ENT_SH{1'b0}}});
        tbl_off  = VA_W'({tbl_idx, {ENT_SH{1'b0}}});
        tbl_base = {dir_entry[VA_W-1:OFF_W], {OFF_W{1'b0}}};
        if (st == ST_RD_TBL || st == ST_WB_TBL)
            addr = tbl_base + tbl_off;
        else
            addr = base + dir_off;
    end
endmodule

// File: rtl/ptw_walker.sv
module ptw_walker
    import ptw_pkg::*;
#(
    parameter int IDX_W = ptw_pkg::IDX_W,
    parameter int OFF_W = ptw_pkg::OFF_W
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      req_valid,
    output logic                      req_ready,
    input  logic [2*IDX_W+OFF_W-1:0]  req_vaddr,
    input  logic                      req_write,
    input  logic                      req_user,
    input  logic [2*IDX_W+OFF_W-1:0]  dir_base,
    output logic                      mem_valid,
    output logic                      mem_we,
    output logic [2*IDX_W+OFF_W-1:0]  mem_addr,
    output logic [2*IDX_W+OFF_W-1:0]  mem_wdata,
    input  logic                      mem_ready,
    input  logic [2*IDX_W+OFF_W-1:0]  mem_rdata,
    output logic                      rsp_valid,
    output logic [1:0]                rsp_cause,
    output logic [2*IDX_W+OFF_W-1:0]  rsp_addr,
    output logic                      rsp_write,
    output logic                      rsp_user
);
    localparam int VA_W   = 2*IDX_W + OFF_W;
    localparam int LEVELS = 2;

    walk_st_e          state;
    xlat_req_t         req_q;
    logic [VA_W-1:0]   pde_q;
    logic [VA_W-1:0]   pte_q;
    cause_e            cause_q;
    logic [VA_W-1:0]   out_q;

    cause_e            rd_cause;
    logic [VA_W-1:0]   lvl_in  [LEVELS];
    logic [VA_W-1:0]   lvl_upd [LEVELS];
    logic              lvl_chg [LEVELS];

    // Both levels are checked through one checker fed by the read data.
    ptw_perm_chk #(.W(VA_W)) u_perm (
        .entry  (mem_rdata),
        .is_wr  (req_q.wr),
        .is_usr (req_q.usr),
        .cause  (rd_cause)
    );

    assign lvl_in[0] = pde_q;
    assign lvl_in[1] = (state == ST_RD_TBL) ? mem_rdata : pte_q;

    for (genvar g = 0; g < LEVELS; g++) begin : g_lvl
        ptw_flag_upd #(.W(VA_W)) u_upd (
            .entry     (lvl_in[g]),
            .set_dirty ((g == LEVELS-1) ? req_q.wr : 1'b0),
            .marked    (lvl_upd[g]),
            .changed   (lvl_chg[g])
        );
    end

    ptw_addr_gen #(.IDX_W(IDX_W), .OFF_W(OFF_W)) u_addr (
        .st        (state),
        .base      (dir_base),
        .vaddr     (req_q.vaddr),
        .dir_entry (pde_q),
        .addr      (mem_addr)
    );

    always_comb begin
        mem_valid = (state == ST_RD_DIR) || (state == ST_RD_TBL) ||
                    (state == ST_WB_DIR) || (state == ST_WB_TBL);
        mem_we    = (state == ST_WB_DIR) || (state == ST_WB_TBL);
        mem_wdata = (state == ST_WB_DIR) ? lvl_upd[0] : lvl_upd[1];
        req_ready = (state == ST_IDLE);
        rsp_valid = (state == ST_RESP);
        rsp_cause = rsp_valid ? cause_q : 2'd0;
        rsp_addr  = rsp_valid ? out_q : '0;
        rsp_write = rsp_valid & req_q.wr;
        rsp_user  = rsp_valid & req_q.usr;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_IDLE;
            req_q   <= '0;
            pde_q   <= '0;
            pte_q   <= '0;
            cause_q <= CAUSE_NONE;
            out_q   <= '0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (req_valid) begin
                        req_q.vaddr <= req_vaddr;
                        req_q.wr    <= req_write;
                        req_q.usr   <= req_user;
                        cause_q     <= CAUSE_NONE;
                        state       <= ST_RD_DIR;
                    end
                end
                ST_RD_DIR: begin
                    if (mem_ready) begin
                        pde_q <= mem_rdata;
                        if (rd_cause != CAUSE_NONE) begin
                            cause_q <= rd_cause;
                            out_q   <= req_q.vaddr;
                            state   <= ST_RESP;
                        end else begin
                            state   <= ST_RD_TBL;
                        end
                    end
                end
                ST_RD_TBL: begin
                    if (mem_ready) begin
                        pte_q <= mem_rdata;
                        if (rd_cause != CAUSE_NONE) begin
                            cause_q <= rd_cause;
                            out_q   <= req_q.vaddr;
                            state   <= ST_RESP;
                        end else begin
                            cause_q <= CAUSE_NONE;
                            out_q   <= {mem_rdata[VA_W-1:OFF_W], req_q.vaddr[OFF_W-1:0]};
                            if (lvl_chg[0])
                                state <= ST_WB_DIR;
                            else if (lvl_chg[1])
                                state <= ST_WB_TBL;
                            else
                                state <= ST_RESP;
                        end
                    end
                end
                ST_WB_DIR: begin
                    if (mem_ready)
                        state <= lvl_chg[1] ? ST_WB_TBL : ST_RESP;
                end
                ST_WB_TBL: begin
                    if (mem_ready)
                        state <= ST_RESP;
                end
                ST_RESP: state <= ST_IDLE;
                default: state <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/ptw_walker_chk.sv
module ptw_walker_chk #(
    parameter int VA_W = 32
) (
    input logic            clk,
    input logic            rst,
    input logic            req_valid,
    input logic            req_ready,
    input logic [VA_W-1:0] req_vaddr,
    input logic            mem_valid,
    input logic            mem_we,
    input logic [VA_W-1:0] mem_addr,
    input logic [VA_W-1:0] mem_wdata,
    input logic            mem_ready,
    input logic            rsp_valid,
    input logic [1:0]      rsp_cause,
    input logic [VA_W-1:0] rsp_addr
);
    logic [VA_W-1:0] seen_va;
    logic            wrote;

    always_ff @(posedge clk) begin
        if (rst) begin
            seen_va <= '0;
            wrote   <= 1'b0;
        end else if (req_valid && req_ready) begin
            seen_va <= req_vaddr;
            wrote   <= 1'b0;
        end else if (mem_valid && mem_ready && mem_we) begin
            wrote   <= 1'b1;
        end
    end

    // R8
    busy_no_accept_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=> !req_ready);

    // R8
    rsp_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |=> !rsp_valid);

    // R8
    rsp_not_ready_chk: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> (!req_ready && !mem_valid));

    // R9
    mem_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_valid && !mem_ready) |=>
            (mem_valid && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));

    // R6
    wb_marks_acc_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_valid && mem_we) |-> (mem_wdata[0] && mem_wdata[5]));

    // R2
    ok_offset_chk: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_cause == 2'd0) |-> (rsp_addr[11:0] == seen_va[11:0]));

    // R3
    fault_addr_chk: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_cause != 2'd0) |-> (rsp_addr == seen_va));

    // R7
    fault_no_write_chk: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_cause != 2'd0) |-> !wrote);
endmodule

bind ptw_walker ptw_walker_chk #(.VA_W(32)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_vaddr (req_vaddr),
    .mem_valid (mem_valid),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .mem_ready (mem_ready),
    .rsp_valid (rsp_valid),
    .rsp_cause (rsp_cause),
    .rsp_addr  (rsp_addr)
);

// File: tb/ptw_walker_bench.sv
module ptw_walker_bench;

    typedef struct packed {
        logic [31:0] pde;
        logic [31:0] pte;
        logic [31:0] va;
        logic        wr;
        logic        usr;
        logic [3:0]  stall;
    } vec_t;

    localparam int NV = 12;
    localparam vec_t VECS [NV] = '{
        '{32'h0000_1007, 32'h0004_5007, 32'h00C0_5123, 1'b0, 1'b0, 4'd0},
        '{32'h0000_1027, 32'h0004_5027, 32'h0100_6ABC, 1'b1, 1'b1, 4'd0},
        '{32'h0000_2027, 32'h0ABC_D027, 32'h01C0_9FFF, 1'b0, 1'b0, 4'd0},
        '{32'h0000_3027, 32'h0777_7067, 32'h0040_2000, 1'b1, 1'b0, 4'd0},
        '{32'h0000_1006, 32'h0000_5007, 32'h0200_0000, 1'b0, 1'b0, 4'd0},
        '{32'h0000_1027, 32'h0000_5006, 32'h0240_A010, 1'b0, 1'b0, 4'd0},
        '{32'h0000_2025, 32'h0000_6007, 32'h0280_B000, 1'b1, 1'b0, 4'd0},
        '{32'h0000_3027, 32'h0000_7003, 32'h02C0_C044, 1'b0, 1'b1, 4'd0},
        '{32'h0000_2000, 32'h0000_9007, 32'h0300_0000, 1'b1, 1'b1, 4'd0},
        '{32'h0000_1007, 32'h0012_3007, 32'h0340_E321, 1'b1, 1'b1, 4'd2},
        '{32'h0000_2005, 32'h0009_9005, 32'h0380_F007, 1'b0, 1'b1, 4'd1},
        '{32'h0000_3007, 32'h0000_8005, 32'h03C1_0000, 1'b1, 1'b0, 4'd1}
    };

    logic        clk = 1'b0;
    logic        rst;
    logic        req_valid, req_write, req_user;
    logic        req_ready;
    logic [31:0] req_vaddr, dir_base;
    logic        mem_valid, mem_we, mem_ready;
    logic [31:0] mem_addr, mem_wdata, mem_rdata;
    logic        rsp_valid, rsp_write, rsp_user;
    logic [1:0]  rsp_cause;
    logic [31:0] rsp_addr;

    logic [31:0] bmem [256];
    logic [3:0]  stall_cfg;
    logic [3:0]  wait_cnt;
    int          n_acc;
    logic [31:0] acc_addr [8];
    logic        acc_we   [8];
    int          n_chk  = 0;
    int          n_fail = 0;
    bit          done   = 0;

    always #4 clk = ~clk;

    ptw_walker u_ptw_walker (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr),
        .req_write(req_write), .req_user(req_user), .dir_base(dir_base),
        .mem_valid(mem_valid), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_ready(mem_ready), .mem_rdata(mem_rdata),
        .rsp_valid(rsp_valid), .rsp_cause(rsp_cause), .rsp_addr(rsp_addr),
        .rsp_write(rsp_write), .rsp_user(rsp_user)
    );

    function automatic logic [7:0] slot(input logic [31:0] a);
        return {a[13:12], a[7:2]};
    endfunction

    assign mem_ready = mem_valid && (wait_cnt == stall_cfg);
    assign mem_rdata = bmem[slot(mem_addr)];

    always @(posedge clk) begin
        if (rst || !mem_valid || mem_ready) wait_cnt <= 4'd0;
        else                                 wait_cnt <= wait_cnt + 4'd1;
        if (mem_valid && mem_ready) begin
            if (n_acc < 8) begin
                acc_addr[n_acc] <= mem_addr;
                acc_we[n_acc]   <= mem_we;
            end
            n_acc <= n_acc + 1;
            if (mem_we) bmem[slot(mem_addr)] <= mem_wdata;
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic bit prot(input logic [31:0] e, input logic wr, input logic usr);
        return (wr && !e[1]) || (usr && !e[2]);
    endfunction

    task automatic run(input vec_t v, input logic [31:0] base);
        logic [31:0] da, ta, npde, npte, eaddr;
        logic [1:0]  ecause;
        int          eacc, ewb, n;
        da = base + {20'd0, v.va[31:22], 2'b00};
        ta = {v.pde[31:12], 12'h000} + {20'd0, v.va[21:12], 2'b00};
        npde = v.pde; npte = v.pte; ewb = 0;
        if (!v.pde[0])                          begin ecause = 2'd1; eacc = 1; end
        else if (prot(v.pde, v.wr, v.usr))      begin ecause = 2'd2; eacc = 1; end
        else if (!v.pte[0])                     begin ecause = 2'd1; eacc = 2; end
        else if (prot(v.pte, v.wr, v.usr))      begin ecause = 2'd2; eacc = 2; end
        else begin
            ecause = 2'd0;
            npde = v.pde | 32'h20;
            npte = v.pte | 32'h20 | (v.wr ? 32'h40 : 32'h0);
            ewb  = (npde != v.pde ? 1 : 0) + (npte != v.pte ? 1 : 0);
            eacc = 2 + ewb;
        end
        eaddr = (ecause == 2'd0) ? {v.pte[31:12], v.va[11:0]} : v.va;

        @(negedge clk);
        dir_base  = base;
        stall_cfg = v.stall;
        bmem[slot(ta)] = v.pte;
        bmem[slot(da)] = v.pde;
        n_acc     = 0;
        req_vaddr = v.va; req_write = v.wr; req_user = v.usr; req_valid = 1'b1;
        chk(req_ready == 1'b1, "R8 ready when idle", {31'd0, req_ready}, 32'd1);
        @(posedge clk);
        n = 0;
        do begin
            @(negedge clk);
            req_valid = 1'b0;
            n++;
        end while (!rsp_valid && n < 200);
        // R8: response timing and ready low while busy
        chk(n == eacc*(v.stall+1)+1, "R8 response cycle", n, eacc*(v.stall+1)+1);
        chk(req_ready == 1'b0, "R8 busy at response", {31'd0, req_ready}, 32'd0);
        chk(rsp_cause == ecause, (ecause == 2'd2) ? "R4 cause" : "R3 cause",
            {30'd0, rsp_cause}, {30'd0, ecause});
        chk(rsp_addr == eaddr, "R2 address", rsp_addr, eaddr);
        chk(rsp_write == v.wr && rsp_user == v.usr, "R5 flags",
            {30'd0, rsp_write, rsp_user}, {30'd0, v.wr, v.usr});
        @(negedge clk);
        chk(rsp_valid == 1'b0 && req_ready == 1'b1, "R8 pulse ends",
            {30'd0, rsp_valid, req_ready}, 32'd1);
        chk(n_acc == eacc, "R7 access count", n_acc, eacc);
        chk(acc_addr[0] == da && !acc_we[0], "R1 directory read", acc_addr[0], da);
        if (eacc >= 2)
            chk(acc_addr[1] == ta && !acc_we[1], "R2 table read", acc_addr[1], ta);
        if (ecause == 2'd0 && npde != v.pde)
            chk(acc_addr[2] == da && acc_we[2], "R6 directory first", acc_addr[2], da);
        chk(bmem[slot(da)] == npde, "R6 directory word", bmem[slot(da)], npde);
        chk(bmem[slot(ta)] == npte, "R6 table word", bmem[slot(ta)], npte);
    endtask

    initial begin
        rst = 1'b1; req_valid = 1'b0; req_write = 1'b0; req_user = 1'b0;
        req_vaddr = '0; dir_base = '0; stall_cfg = '0; n_acc = 0;
        for (int i = 0; i < 256; i++) bmem[i] = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R10 reset state
        chk(req_ready == 1'b1, "R10 ready", {31'd0, req_ready}, 32'd1);
        chk(mem_valid == 1'b0, "R10 mem idle", {31'd0, mem_valid}, 32'd0);
        chk(rsp_valid == 1'b0, "R10 no response", {31'd0, rsp_valid}, 32'd0);

        for (int k = 0; k < NV; k++) run(VECS[k], 32'h0000_0000);

        // R1 nonzero directory base
        run('{32'h0000_1007, 32'h0055_5007, 32'h0080_3456, 1'b0, 1'b0, 4'd0},
            32'h0000_3000);
        // R4 user read of supervisor directory word under stall
        run('{32'h0000_2003, 32'h0000_1007, 32'h0100_1000, 1'b0, 1'b1, 4'd3},
            32'h0000_0000);
        // R7 repeat of a finished write: no write-back, two accesses
        run('{32'h0000_1067, 32'h0004_5067, 32'h0100_6ABC, 1'b1, 1'b1, 4'd0},
            32'h0000_0000);

        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        #(8 * 150000);
        if (!done) begin
            done = 1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog R8 actual=hung expected=done");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

endmodule